// File: doc/BRIEF.md
# Mailbox Protocol Discovery Enumerator

This block builds, at bring-up, the list of protocols that a data-object mailbox supports. A pulse on `start_i` first asks the external requester engine to abort, which resets the mailbox. If the abort succeeds, the block sends discovery requests. Each request carries a one-dword payload with an index, and the first index is 0. Each response yields one vendor-ID/type pair, which goes into a table. The same response also names the index for the next request. The walk ends when a response names index 0. The table depth is a parameter.

Once the walk is complete, other logic presents a vendor-ID/type pair and gets a combinational supported/unsupported answer in the same cycle. A second output combines that answer with a byte-size check and the mailbox health. It tells whether a task may be handed to the mailbox at all.

Top module: `proto_enum`

## Requirements
- R1: After an accepted `start_i`, `abort_req_o` is held high until `abort_done_i` is seen, and no discovery request is issued while it is high.
- R2: Every discovery request carries vendor ID 0x0001 and type 0x00. Its payload dword has the index in bits 7:0 and zeros above, and the first request after a good abort uses index 0.
- R3: Each later request uses the index found in bits 31:24 of the previous response. A response whose bits 31:24 are 0 ends the walk and raises `ready_o`.
- R4: Each accepted response stores the vendor ID from payload bits 15:0 and the type from bits 23:16. Once `ready_o` is high, a query hits only when both fields exactly match a stored pair.
- R5: The pair vendor 0x0001 / type 0x00 always hits, whatever the table holds and whatever the block state.
- R6: While `ready_o` is low, during a walk or after a failed one, every pair other than the R5 pair misses.
- R7: A response whose payload length `rsp_len_i` is not exactly 1 dword stops the walk, sets `len_err_o` and leaves `ready_o` low.
- R8: If the table holds `DEPTH` entries and the last response still names a non-zero next index, `overflow_o` is set, the walk stops and no further request is issued.
- R9: If the abort reports failure (`abort_ok_i` low with `abort_done_i`), `dead_o` is set, no request is issued and `task_ok_o` stays low.
- R10: `task_ok_o` is high only when the queried pair hits, the byte count `qry_bytes_i` is a multiple of 4, and `dead_o` is low.
- R11: While `req_valid_o` is high and `req_ready_i` low, `req_valid_o` stays high and `req_dw_o` stays unchanged.
- R12: A `start_i` taken while not busy clears the table and all status flags, including `dead_o`, before a new walk. A `start_i` taken while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin abort and enumeration |
| abort_req_o | output | 1 | Abort request to requester engine |
| abort_done_i | input | 1 | Abort finished (one cycle) |
| abort_ok_i | input | 1 | Abort result, valid with abort_done_i |
| req_valid_o | output | 1 | Discovery request valid |
| req_ready_i | input | 1 | Requester engine accepts request |
| req_vid_o | output | 16 | Request protocol vendor ID |
| req_type_o | output | 8 | Request protocol type |
| req_dw_o | output | 32 | Request payload dword (index in 7:0) |
| rsp_valid_i | input | 1 | Response available (one cycle) |
| rsp_len_i | input | LEN_W | Received payload length in dwords |
| rsp_dw_i | input | 32 | Response payload dword |
| qry_vid_i | input | 16 | Query vendor ID |
| qry_type_i | input | 8 | Query type |
| qry_bytes_i | input | BYTES_W | Query task request size in bytes |
| qry_hit_o | output | 1 | Pair supported |
| task_ok_o | output | 1 | Task may be submitted |
| ready_o | output | 1 | Enumeration completed successfully |
| busy_o | output | 1 | Abort or walk in progress |
| len_err_o | output | 1 | Walk failed on a bad response length |
| overflow_o | output | 1 | Walk failed on a full table |
| dead_o | output | 1 | Abort failed; mailbox unusable |

## Verification
The assertions assume that the requester engine pulses `abort_done_i` only while an abort is requested, and `rsp_valid_i` only for a request it has accepted. They also assume one response per request. The bench drives a single engine model that waits for `abort_req_o` or for a request handshake before it answers. It never raises `rsp_valid_i` outside that window, so the stimulus always meets these assumptions. The engine model also holds `req_ready_i` low for a few cycles on some requests, which exercises the hold rule.

// File: rtl/proto_enum_pkg.sv
package proto_enum_pkg;
  localparam int VID_W  = 16;
  localparam int TYPE_W = 8;
  localparam int IDX_W  = 8;
  localparam int DW_W   = 32;

  localparam logic [VID_W-1:0]  DISC_VID  = 16'h0001;
  localparam logic [TYPE_W-1:0] DISC_TYPE = 8'h00;

  typedef struct packed {
    logic [VID_W-1:0]  vid;
    logic [TYPE_W-1:0] ptype;
  } proto_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ABORT, ST_REQ, ST_WAIT, ST_DONE, ST_FAIL
  } walk_st_e;

  // response dword: vid 15:0, type 23:16, next index 31:24
  function automatic proto_t rsp_proto(logic [DW_W-1:0] dw);
    proto_t p;
    p.vid   = dw[15:0];
    p.ptype = dw[23:16];
    return p;
  endfunction

  function automatic logic [IDX_W-1:0] rsp_next(logic [DW_W-1:0] dw);
    return dw[31:24];
  endfunction
endpackage

// File: rtl/proto_table.sv
module proto_table
  import proto_enum_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  proto_t           wr_data_i,
  input  logic             valid_i,
  input  proto_t           qry_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [DEPTH-1:0] match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_q <= '0;
    else if (clr_i)                             cnt_q <= '0;
    else if (wr_i && cnt_q < CNT_W'(DEPTH))     cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    proto_t ent_q;
    always_ff @(posedge clk_i) begin
      if (wr_i && cnt_q == CNT_W'(i)) ent_q <= wr_data_i;
    end
    assign match[i] = (CNT_W'(i) < cnt_q) && (ent_q == qry_i);
  end

  assign cnt_o = cnt_q;
  assign hit_o = ((qry_i.vid == DISC_VID) && (qry_i.ptype == DISC_TYPE)) ||
                 (valid_i && (|match));

  // R8
  no_wr_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> cnt_q < CNT_W'(DEPTH));

  // R8
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/proto_walker.sv
module proto_walker
  import proto_enum_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LEN_W = 18,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             abort_req_o,
  input  logic             abort_done_i,
  input  logic             abort_ok_i,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic [DW_W-1:0]  req_dw_o,
  input  logic             rsp_valid_i,
  input  logic [LEN_W-1:0] rsp_len_i,
  input  logic [DW_W-1:0]  rsp_dw_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             clr_o,
  output logic             wr_o,
  output proto_t           wr_data_o,
  output logic             ready_o,
  output logic             busy_o,
  output logic             len_err_o,
  output logic             ovf_o,
  output logic             dead_o
);
  walk_st_e         st_q;
  logic [IDX_W-1:0] idx_q;
  logic             ready_q, len_err_q, ovf_q, dead_q;
  logic             len_ok, last_slot;
  logic [IDX_W-1:0] nxt;

  assign busy_o    = (st_q == ST_ABORT) || (st_q == ST_REQ) || (st_q == ST_WAIT);
  assign clr_o     = start_i && !busy_o;
  assign len_ok    = (rsp_len_i == LEN_W'(1));
  assign last_slot = (cnt_i == CNT_W'(DEPTH - 1));
  assign nxt       = rsp_next(rsp_dw_i);
  assign wr_o      = (st_q == ST_WAIT) && rsp_valid_i && len_ok;
  assign wr_data_o = rsp_proto(rsp_dw_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      idx_q     <= '0;
      ready_q   <= 1'b0;
      len_err_q <= 1'b0;
      ovf_q     <= 1'b0;
      dead_q    <= 1'b0;
    end else begin
      case (st_q)
        ST_ABORT: if (abort_done_i) begin
          if (abort_ok_i) st_q <= ST_REQ;
          else begin
            dead_q <= 1'b1;
            st_q   <= ST_FAIL;
          end
        end
        ST_REQ: if (req_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) begin
          if (!len_ok) begin
            len_err_q <= 1'b1;
            st_q      <= ST_FAIL;
          end else if (nxt == '0) begin
            ready_q <= 1'b1;
            st_q    <= ST_DONE;
          end else if (last_slot) begin
            ovf_q <= 1'b1;
            st_q  <= ST_FAIL;
          end else begin
            idx_q <= nxt;
            st_q  <= ST_REQ;
          end
        end
        default: if (start_i) begin
          st_q      <= ST_ABORT;
          idx_q     <= '0;
          ready_q   <= 1'b0;
          len_err_q <= 1'b0;
          ovf_q     <= 1'b0;
          dead_q    <= 1'b0;
        end
      endcase
    end
  end

  assign abort_req_o = (st_q == ST_ABORT);
  assign req_valid_o = (st_q == ST_REQ);
  assign req_dw_o    = {{(DW_W-IDX_W){1'b0}}, idx_q};
  assign ready_o     = ready_q;
  assign len_err_o   = len_err_q;
  assign ovf_o       = ovf_q;
  assign dead_o      = dead_q;

  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_dw_o));

  // R2
  first_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_req_o && abort_done_i && abort_ok_i |=> req_valid_o && req_dw_o == '0);

  // R7
  len_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) && rsp_valid_i && !len_ok |=> len_err_o && !ready_o && !busy_o);

  // R9
  dead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_req_o && abort_done_i && !abort_ok_i |=> dead_o && !busy_o && !req_valid_o);

  // R3
  ready_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !len_err_o && !ovf_o && !dead_o);
endmodule

// File: rtl/proto_enum.sv
module proto_enum
  import proto_enum_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int LEN_W   = 18,
  parameter int BYTES_W = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic               abort_req_o,
  input  logic               abort_done_i,
  input  logic               abort_ok_i,
  output logic               req_valid_o,
  input  logic               req_ready_i,
  output logic [15:0]        req_vid_o,
  output logic [7:0]         req_type_o,
  output logic [31:0]        req_dw_o,
  input  logic               rsp_valid_i,
  input  logic [LEN_W-1:0]   rsp_len_i,
  input  logic [31:0]        rsp_dw_i,
  input  logic [15:0]        qry_vid_i,
  input  logic [7:0]         qry_type_i,
  input  logic [BYTES_W-1:0] qry_bytes_i,
  output logic               qry_hit_o,
  output logic               task_ok_o,
  output logic               ready_o,
  output logic               busy_o,
  output logic               len_err_o,
  output logic               overflow_o,
  output logic               dead_o
);
  logic             clr, wr;
  proto_t           wr_data, qry;
  logic [CNT_W-1:0] cnt;

  assign qry.vid   = qry_vid_i;
  assign qry.ptype = qry_type_i;

  proto_walker #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_walker (
    .clk_i, .rst_ni, .start_i,
    .abort_req_o, .abort_done_i, .abort_ok_i,
    .req_valid_o, .req_ready_i, .req_dw_o,
    .rsp_valid_i, .rsp_len_i, .rsp_dw_i,
    .cnt_i(cnt), .clr_o(clr), .wr_o(wr), .wr_data_o(wr_data),
    .ready_o, .busy_o, .len_err_o, .ovf_o(overflow_o), .dead_o
  );

  proto_table #(.DEPTH(DEPTH)) u_table (
    .clk_i, .rst_ni, .clr_i(clr), .wr_i(wr), .wr_data_i(wr_data),
    .valid_i(ready_o), .qry_i(qry), .cnt_o(cnt), .hit_o(qry_hit_o)
  );

  assign req_vid_o  = DISC_VID;
  assign req_type_o = DISC_TYPE;
  assign task_ok_o  = qry_hit_o && !dead_o &&
                      ((qry_bytes_i & BYTES_W'(3)) == '0);

  // R5
  disc_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qry_vid_i == DISC_VID && qry_type_i == DISC_TYPE) |-> qry_hit_o);

  // R10
  task_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_o |-> !task_ok_o);
endmodule

// File: tb/tb_proto_enum.sv
`timescale 1ns/1ps
module tb_proto_enum;
  localparam int DEPTH = 8;
  localparam int LEN_W = 18;
  localparam int BW    = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start = 0, ab_done = 0, ab_ok = 0, rq_ready = 0, rs_valid = 0;
  logic [LEN_W-1:0] rs_len = '0;
  logic [31:0] rs_dw = '0;
  logic [15:0] q_vid = '0;
  logic [7:0]  q_type = '0;
  logic [BW-1:0] q_bytes = '0;
  logic ab_req, rq_valid, hit, tok, rdy, busy, lerr, ovf, dead;
  logic [15:0] rq_vid;
  logic [7:0]  rq_type;
  logic [31:0] rq_dw;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  proto_enum #(.DEPTH(DEPTH), .LEN_W(LEN_W), .BYTES_W(BW)) dut (
    .clk_i(clk), .rst_ni, .start_i(start),
    .abort_req_o(ab_req), .abort_done_i(ab_done), .abort_ok_i(ab_ok),
    .req_valid_o(rq_valid), .req_ready_i(rq_ready),
    .req_vid_o(rq_vid), .req_type_o(rq_type), .req_dw_o(rq_dw),
    .rsp_valid_i(rs_valid), .rsp_len_i(rs_len), .rsp_dw_i(rs_dw),
    .qry_vid_i(q_vid), .qry_type_i(q_type), .qry_bytes_i(q_bytes),
    .qry_hit_o(hit), .task_ok_o(tok), .ready_o(rdy), .busy_o(busy),
    .len_err_o(lerr), .overflow_o(ovf), .dead_o(dead)
  );

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // monitor: pops expected index when a request handshake is about to complete
  always @(negedge clk) begin
    #2;
    if (rst_ni && rq_valid && rq_ready) begin
      if (exp_q.size() == 0) check("R3 unexpected request", rq_dw, 32'hFFFF_FFFF);
      else begin
        int e;
        e = exp_q.pop_front();
        check("R2/R3 request dword", rq_dw, e);
        check("R2 request vid", {16'h0, rq_vid}, 32'h0001);
        check("R2 request type", {24'h0, rq_type}, 32'h0);
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk); #1 start = 1;
    @(negedge clk); #1 start = 0;
  endtask

  task automatic do_abort(bit ok, int hold);
    @(negedge clk);
    while (!ab_req) @(negedge clk);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R1 abort held", {30'h0, ab_req, rq_valid}, 32'h2);
    end
    #1 ab_done = 1; ab_ok = ok;
    @(negedge clk); #1 ab_done = 0; ab_ok = 0;
  endtask

  task automatic do_step(int idx, int hold, logic [31:0] dw, int len);
    logic [31:0] cap;
    exp_q.push_back(idx);
    @(negedge clk);
    while (!rq_valid) @(negedge clk);
    cap = rq_dw;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R11 request held", {31'h0, rq_valid}, 32'h1);
      check("R11 payload stable", rq_dw, cap);
    end
    #1 rq_ready = 1;
    @(negedge clk); #1 rq_ready = 0;
    rs_valid = 1; rs_len = LEN_W'(len); rs_dw = dw;
    @(negedge clk); #1 rs_valid = 0; rs_dw = '0; rs_len = '0;
  endtask

  task automatic query(logic [15:0] v, logic [7:0] t, int b);
    @(negedge clk); #1 q_vid = v; q_type = t; q_bytes = BW'(b);
    #1;
  endtask

  task automatic status(string rq, bit r, bit l, bit o, bit d, bit bz);
    check(rq, {27'h0, rdy, lerr, ovf, dead, busy}, {27'h0, r, l, o, d, bz});
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
          n_chk++; n_err++;
          $display("FAIL watchdog act=timeout exp=completion");
          $display("Result: errors=%0d of %0d checks", n_err, n_chk);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    rst_ni = 1;
    // reset state
    @(negedge clk);
    status("R12 reset status", 0, 0, 0, 0, 0);
    check("R1 reset no requests", {30'h0, ab_req, rq_valid}, 32'h0);
    query(16'h0001, 8'h00, 4);
    check("R5 disc pair at reset", {31'h0, hit}, 32'h1);
    query(16'h1E98, 8'h02, 4);
    check("R6 other pair at reset", {31'h0, hit}, 32'h0);

    // walk A: indices 0 -> 5 -> 2 -> end
    pulse_start();
    do_abort(1, 2);
    do_step(0, 0, 32'h0500_0001, 1);
    do_step(5, 3, 32'h0202_1E98, 1);
    @(negedge clk);
    status("R6 mid-walk not ready", 0, 0, 0, 0, 1);
    query(16'h1E98, 8'h02, 4);
    check("R6 stored pair before ready", {31'h0, hit}, 32'h0);
    do_step(2, 1, 32'h0003_1E98, 1);
    @(negedge clk);
    status("R3 ready after next=0", 1, 0, 0, 0, 0);
    query(16'h1E98, 8'h02, 8);
    check("R4 hit entry 2", {31'h0, hit}, 32'h1);
    check("R10 task ok aligned", {31'h0, tok}, 32'h1);
    query(16'h1E98, 8'h03, 0);
    check("R4 hit entry 3", {31'h0, hit}, 32'h1);
    query(16'h1E98, 8'h04, 4);
    check("R4 type mismatch", {31'h0, hit}, 32'h0);
    check("R10 unsupported rejected", {31'h0, tok}, 32'h0);
    query(16'h1E99, 8'h02, 4);
    check("R4 vid mismatch", {31'h0, hit}, 32'h0);
    query(16'h1E98, 8'h02, 6);
    check("R10 unaligned size rejected", {31'h0, tok}, 32'h0);

    // length error
    pulse_start();
    do_abort(1, 0);
    do_step(0, 0, 32'h0000_0001, 2);
    @(negedge clk);
    status("R7 length error", 0, 1, 0, 0, 0);
    query(16'h1E98, 8'h02, 4);
    check("R12 table cleared by start", {31'h0, hit}, 32'h0);

    // overflow: DEPTH entries, all with non-zero next index
    pulse_start();
    do_abort(1, 0);
    for (int k = 0; k < DEPTH; k++)
      do_step(k, 0, {8'(k + 1), 8'(k), 16'h2000 + 16'(k)}, 1);
    @(negedge clk);
    status("R8 overflow", 0, 0, 1, 0, 0);
    repeat (3) @(negedge clk);
    check("R8 no request after overflow", {31'h0, rq_valid}, 32'h0);
    query(16'h2003, 8'h03, 4);
    check("R6 miss after failed walk", {31'h0, hit}, 32'h0);

    // abort failure
    pulse_start();
    do_abort(0, 1);
    @(negedge clk);
    status("R9 dead after abort fail", 0, 0, 0, 1, 0);
    repeat (2) @(negedge clk);
    check("R9 no request when dead", {31'h0, rq_valid}, 32'h0);
    query(16'h0001, 8'h00, 4);
    check("R5 disc pair while dead", {31'h0, hit}, 32'h1);
    check("R9 task rejected when dead", {31'h0, tok}, 32'h0);

    // recovery, start while busy ignored
    pulse_start();
    pulse_start();
    do_abort(1, 3);
    do_step(0, 0, 32'h0000_0001, 1);
    @(negedge clk);
    status("R12 restart clears dead", 1, 0, 0, 0, 0);
    query(16'h0001, 8'h00, 12);
    check("R10 disc task accepted", {31'h0, tok}, 32'h1);
    query(16'h1E98, 8'h02, 4);
    check("R4 old entry gone", {31'h0, hit}, 32'h0);

    check("R3 all expected requests seen", exp_q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule